// File: doc/BRIEF.md
# Dual-Rate Double-Data-Rate Serial Transmitter

The block turns 10-bit words, already line-coded (8b/10b or another DC-balanced code), into a single serial bit stream. Words arrive on a parallel bus together with a byte clock that the sender drives in step with the data. A rate input chooses between two capture schemes. At full rate a fresh word is taken on both the rising and the falling edge of the byte clock. At half rate only the falling edge takes a word, and the bus value around the rising edge is ignored.

The serial bit clock is an input that runs at twenty times the byte clock. At full rate one bit goes out per bit clock. At half rate every bit is held for two bit clocks, so the line rate is halved. Captured words cross into the bit-clock domain through toggle handshakes and a small holding queue. Each word is loaded into a 10-bit shift register, and bit 0 leaves first.

Serialization starts only once two words are queued. Until then, and again after any change of the rate input, the line carries a fixed idle word. A loopback port returns every serialized word, once and in order, as a parallel word with a one-cycle strobe.

Top module: `dual_rate_ser_tx`

## Requirements
- R1: With `rateFull` high, the word on `txData` is captured at every rising and every falling edge of `byteClk`, and the words are serialized in capture order.
- R2: With `rateFull` low, only falling edges of `byteClk` capture a word, and the value on `txData` around a rising edge has no effect on `serOut`.
- R3: Each word is sent with bit 0 first. At full rate each bit lasts one `bitClk` period, so a word fills 10 consecutive bit periods. Word slots begin 3 `bitClk` rising edges after reset release and follow each other with no gap.
- R4: At half rate each bit is held for exactly two `bitClk` periods, so a word fills 20 bit periods. Slots begin at the same point as in R3.
- R5: After reset the line sends the idle word 0x17C (bit 0 first) in every slot until two captured words are queued. At least two idle slots come before the first data word.
- R6: A change of `rateFull` discards every queued word and restarts the slot timing with idle words. Serialization resumes, in capture order, with the words captured after the change.
- R7: In steady state every captured word is serialized exactly once, with no drops and no duplicates.
- R8: With `loopEn` high, each serialized data word appears once on `rxData` in serialization order. `rxValid` is high for exactly one `bitClk` cycle per word.
- R9: With `loopEn` low, `rxValid` stays low.
- R10: While `rstN` is low, `serOut` is 0 (bit 0 of the idle word) and `rxValid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bitClk | input | 1 | Serial bit clock, twenty times the byte clock |
| byteClk | input | 1 | Byte clock that comes with the parallel data |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| rateFull | input | 1 | 1: capture on both byte-clock edges; 0: capture on falling edges only |
| loopEn | input | 1 | Enables loopback delivery on rxData/rxValid |
| txData | input | 10 | Pre-encoded parallel transmit word |
| serOut | output | 1 | Serial bit stream, bit 0 of each word first |
| rxData | output | 10 | Loopback copy of the most recently serialized word |
| rxValid | output | 1 | One-cycle strobe marking a new rxData word |

## Verification
The bench aims at the hand-off from idle to data after reset and after a rate change. A design that began with fewer than two queued words, or kept stale words through a rate change, would show a missing idle slot or an extra, out-of-order word. At half rate it places an unrelated value on the bus around each rising byte-clock edge. A design that still captured on that edge would serialize the unrelated word. It also checks that every bit is repeated exactly twice, so a design that halved the rate wrongly would break the pairs. Word order and the gapless slot grid at full rate catch dropped or duplicated words, a reversed bit order, and a capture order that swaps the rising and falling words.

// File: rtl/txser_pkg.sv
`timescale 1ns/1ps
package txser_pkg;
  localparam int WORD_W     = 10;
  localparam int FIFO_DEPTH = 4;
  localparam int PTR_W      = $clog2(FIFO_DEPTH);
  localparam int CNT_W      = PTR_W + 1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } serState_e;

  // strobes from control to datapath, all in the bit-clock domain
  typedef struct packed {
    logic             push;
    logic             pushFall;
    logic [PTR_W-1:0] wrPtr;
    logic             pop;
    logic [PTR_W-1:0] rdPtr;
    logic             loadIdle;
    logic             shift;
  } serStrb_t;
endpackage

// File: rtl/txser_sync.sv
`timescale 1ns/1ps
module txser_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/txser_capture.sv
`timescale 1ns/1ps
module txser_capture #(
  parameter int WORD_W = txser_pkg::WORD_W
) (
  input  logic              byteClk,
  input  logic              rstN,
  input  logic              rateFull,
  input  logic [WORD_W-1:0] txData,
  output logic [WORD_W-1:0] riseWord,
  output logic              riseTgl,
  output logic [WORD_W-1:0] fallWord,
  output logic              fallTgl
);
  // rising-edge slot, used only at full rate
  always_ff @(posedge byteClk or negedge rstN) begin
    if (!rstN) begin
      riseWord <= '0;
      riseTgl  <= 1'b0;
    end else if (rateFull) begin
      riseWord <= txData;
      riseTgl  <= ~riseTgl;
    end
  end

  // falling-edge slot, used at both rates
  always_ff @(negedge byteClk or negedge rstN) begin
    if (!rstN) begin
      fallWord <= '0;
      fallTgl  <= 1'b0;
    end else begin
      fallWord <= txData;
      fallTgl  <= ~fallTgl;
    end
  end
endmodule

// File: rtl/txser_ctrl.sv
`timescale 1ns/1ps
module txser_ctrl
  import txser_pkg::*;
#(
  parameter int WORD_W      = txser_pkg::WORD_W,
  parameter int SYNC_STAGES = 2,
  parameter int START_WORDS = 2
) (
  input  logic     bitClk,
  input  logic     rstN,
  input  logic     rateFull,
  input  logic     riseTgl,
  input  logic     fallTgl,
  output serStrb_t strb
);
  localparam int WARM   = SYNC_STAGES + 1;
  localparam int WARM_W = $clog2(WARM + 1);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int N_SYNC = 3;

  // synchronize rise toggle, fall toggle and rate select
  logic [N_SYNC-1:0] asyncIn;
  logic [N_SYNC-1:0] syncOut;
  assign asyncIn = {rateFull, fallTgl, riseTgl};

  generate
    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
      txser_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk (bitClk),
        .rstN(rstN),
        .d   (asyncIn[g]),
        .q   (syncOut[g])
      );
    end
  endgenerate

  logic riseS, fallS, rateS;
  assign riseS = syncOut[0];
  assign fallS = syncOut[1];
  assign rateS = syncOut[2];

  logic              riseQ, fallQ, rateQ, halfTick;
  logic [WARM_W-1:0] warmCnt;
  logic [BIT_W-1:0]  bitCnt;
  serState_e         state;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  cnt;

  logic armed, rateChg, pushRise, pushFall, pushNow, popNow;
  logic shiftEn, boundary;

  assign armed    = (warmCnt == WARM_W'(WARM));
  assign rateChg  = armed && (rateS != rateQ);
  assign pushRise = riseS ^ riseQ;
  assign pushFall = fallS ^ fallQ;
  assign pushNow  = (pushRise || pushFall) && !rateChg;
  assign shiftEn  = armed && !rateChg && (rateQ || halfTick);
  assign boundary = shiftEn && (bitCnt == BIT_W'(WORD_W - 1));

  always_comb begin
    popNow = 1'b0;
    if (boundary) begin
      if (state == ST_RUN) popNow = (cnt != '0);
      else                 popNow = (cnt >= CNT_W'(START_WORDS));
    end
  end

  always_comb begin
    strb.push     = pushNow;
    strb.pushFall = pushFall;
    strb.wrPtr    = wrPtr;
    strb.pop      = popNow;
    strb.rdPtr    = rdPtr;
    strb.loadIdle = rateChg || (boundary && !popNow);
    strb.shift    = shiftEn && !boundary;
  end

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      warmCnt  <= '0;
      riseQ    <= 1'b0;
      fallQ    <= 1'b0;
      rateQ    <= 1'b1;
      halfTick <= 1'b0;
      bitCnt   <= '0;
      state    <= ST_IDLE;
      wrPtr    <= '0;
      rdPtr    <= '0;
      cnt      <= '0;
    end else begin
      riseQ <= riseS;
      fallQ <= fallS;
      if (!armed) begin
        warmCnt <= warmCnt + WARM_W'(1);
        rateQ   <= rateS;
      end else if (rateChg) begin
        rateQ <= rateS;
      end
      halfTick <= armed && !rateChg && !halfTick;
      if (rateChg) begin
        bitCnt <= '0;
        state  <= ST_IDLE;
        wrPtr  <= '0;
        rdPtr  <= '0;
        cnt    <= '0;
      end else begin
        if (boundary)     bitCnt <= '0;
        else if (shiftEn) bitCnt <= bitCnt + BIT_W'(1);
        if (boundary) state <= popNow ? ST_RUN : ST_IDLE;
        if (pushNow) wrPtr <= wrPtr + PTR_W'(1);
        if (popNow)  rdPtr <= rdPtr + PTR_W'(1);
        cnt <= cnt + CNT_W'(pushNow) - CNT_W'(popNow);
      end
    end
  end

  // R1: rising and falling captures never land in the same bit clock
  assert_one_push_R1: assert property (@(posedge bitClk) disable iff (!rstN)
    !(pushRise && pushFall));

  // R7: the holding queue never overflows
  assert_no_overflow_R7: assert property (@(posedge bitClk) disable iff (!rstN)
    !(pushNow && !popNow && cnt == CNT_W'(FIFO_DEPTH)));

  // R7: while the rate is steady a running stream always has a word ready
  assert_no_underrun_R7: assert property (@(posedge bitClk) disable iff (!rstN)
    (boundary && state == ST_RUN && rateS == rateQ) |-> (cnt != '0));
endmodule

// File: rtl/txser_datapath.sv
`timescale 1ns/1ps
module txser_datapath
  import txser_pkg::*;
#(
  parameter int                WORD_W    = txser_pkg::WORD_W,
  parameter logic [WORD_W-1:0] IDLE_WORD = 10'h17C
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  serStrb_t          strb,
  input  logic [WORD_W-1:0] riseWord,
  input  logic [WORD_W-1:0] fallWord,
  input  logic              loopEn,
  output logic              serOut,
  output logic [WORD_W-1:0] rxData,
  output logic              rxValid
);
  logic [WORD_W-1:0] fifoMem [FIFO_DEPTH];
  logic [WORD_W-1:0] headWord;
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge bitClk) begin
    if (strb.push) fifoMem[strb.wrPtr] <= strb.pushFall ? fallWord : riseWord;
  end

  assign headWord = fifoMem[strb.rdPtr];

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      shreg <= IDLE_WORD;
    end else if (strb.loadIdle) begin
      shreg <= IDLE_WORD;
    end else if (strb.pop) begin
      shreg <= headWord;
    end else if (strb.shift) begin
      shreg <= {1'b0, shreg[WORD_W-1:1]};
    end
  end

  assign serOut = shreg[0];

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= strb.pop && loopEn;
      if (strb.pop && loopEn) rxData <= headWord;
    end
  end

  // R9: no loopback strobe unless loopback was enabled a cycle earlier
  assert_loop_off_R9: assert property (@(posedge bitClk) disable iff (!rstN)
    !$past(loopEn) |-> !rxValid);

  // R8: each loopback word is strobed for a single cycle
  assert_strobe_gap_R8: assert property (@(posedge bitClk) disable iff (!rstN)
    rxValid |=> !rxValid);
endmodule

// File: rtl/dual_rate_ser_tx.sv
`timescale 1ns/1ps
module dual_rate_ser_tx
  import txser_pkg::*;
#(
  parameter int                WORD_W      = txser_pkg::WORD_W,
  parameter logic [WORD_W-1:0] IDLE_WORD   = 10'h17C,
  parameter int                SYNC_STAGES = 2,
  parameter int                START_WORDS = 2
) (
  input  logic              bitClk,
  input  logic              byteClk,
  input  logic              rstN,
  input  logic              rateFull,
  input  logic              loopEn,
  input  logic [WORD_W-1:0] txData,
  output logic              serOut,
  output logic [WORD_W-1:0] rxData,
  output logic              rxValid
);
  logic [WORD_W-1:0] riseWord, fallWord;
  logic              riseTgl, fallTgl;
  serStrb_t          strb;

  txser_capture #(.WORD_W(WORD_W)) i_capture (
    .byteClk (byteClk),
    .rstN    (rstN),
    .rateFull(rateFull),
    .txData  (txData),
    .riseWord(riseWord),
    .riseTgl (riseTgl),
    .fallWord(fallWord),
    .fallTgl (fallTgl)
  );

  txser_ctrl #(
    .WORD_W     (WORD_W),
    .SYNC_STAGES(SYNC_STAGES),
    .START_WORDS(START_WORDS)
  ) i_ctrl (
    .bitClk  (bitClk),
    .rstN    (rstN),
    .rateFull(rateFull),
    .riseTgl (riseTgl),
    .fallTgl (fallTgl),
    .strb    (strb)
  );

  txser_datapath #(
    .WORD_W   (WORD_W),
    .IDLE_WORD(IDLE_WORD)
  ) i_datapath (
    .bitClk  (bitClk),
    .rstN    (rstN),
    .strb    (strb),
    .riseWord(riseWord),
    .fallWord(fallWord),
    .loopEn  (loopEn),
    .serOut  (serOut),
    .rxData  (rxData),
    .rxValid (rxValid)
  );
endmodule

// File: tb/test_dual_rate_ser_tx.sv
`timescale 1ns/1ps
module test_dual_rate_ser_tx;
  localparam int NV = 16;
  localparam int MAXS = 1024;
  localparam logic [9:0] IDLE = 10'h17C;
  localparam logic [9:0] GARB = 10'h3FF;
  localparam logic [9:0] VEC [NV] = '{
    10'h2A5, 10'h15A, 10'h0F3, 10'h30C, 10'h1E1, 10'h21E, 10'h333, 10'h0CC,
    10'h3C3, 10'h03C, 10'h2D2, 10'h12D, 10'h399, 10'h066, 10'h1B4, 10'h24B};

  logic bitClk = 1'b0;
  logic byteClk = 1'b0;
  logic rstN = 1'b0;
  logic rateFull = 1'b1;
  logic loopEn = 1'b1;
  logic [9:0] txData = 10'h2A5;
  logic serOut;
  logic [9:0] rxData;
  logic rxValid;

  int nChk = 0;
  int nFail = 0;
  logic stream [MAXS];
  int recN = 0;
  bit recOn = 1'b0;
  logic [9:0] rxLog [MAXS];
  int rxN = 0;

  always #4 bitClk = ~bitClk;     // 125 MHz
  always #80 byteClk = ~byteClk;  // one twentieth of the bit clock

  dual_rate_ser_tx i_dual_rate_ser_tx (
    .bitClk(bitClk), .byteClk(byteClk), .rstN(rstN), .rateFull(rateFull),
    .loopEn(loopEn), .txData(txData), .serOut(serOut), .rxData(rxData),
    .rxValid(rxValid));

  always @(negedge bitClk) begin
    if (recOn && recN < MAXS) begin
      stream[recN] = serOut;
      recN++;
    end
    if (rxValid && rxN < MAXS) begin
      rxLog[rxN] = rxData;
      rxN++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] wordAt(input int p, input int b);
    logic [9:0] w = 'x;
    for (int i = 0; i < 10; i++)
      if (p + i * b >= 0 && p + i * b < recN) w[i] = stream[p + i * b];
    return w;
  endfunction

  // find the first data word behind an idle slot, then walk the table
  task automatic decode(input int b, input bit fromReset);
    int p = -1;
    for (int q = 10 * b; q + 10 * b <= recN; q++)
      if (p < 0 && wordAt(q, b) === VEC[0] && wordAt(q - 10 * b, b) === IDLE) p = q;
    chk(p >= 0, "R6 idle-to-data handoff found", p, 0);
    if (p < 0) return;
    if (fromReset) begin
      for (int i = 0; i < 3; i++) chk(stream[i] === 1'b0, "R5 warm-up idle bit", stream[i], 0);
      chk((p - 3) % (10 * b) == 0, b == 1 ? "R3 slot grid" : "R4 slot grid", p, 3);
      chk(p - 3 >= 20 * b, "R5 two idle slots first", p, 3 + 20 * b);
      for (int j = 3; j < p; j += 10 * b)
        chk(wordAt(j, b) === IDLE, "R5 idle word", wordAt(j, b), IDLE);
    end
    for (int k = 0; k < NV; k++) begin
      logic [9:0] got = wordAt(p + k * 10 * b, b);
      chk(got === VEC[k], b == 1 ? "R1 R3 R7 word order" : "R2 R4 R7 word order", got, VEC[k]);
      if (b == 2) begin
        bit pairs = 1'b1;
        for (int i = 0; i < 10; i++)
          if (stream[p + k * 20 + 2 * i] !== stream[p + k * 20 + 2 * i + 1]) pairs = 1'b0;
        chk(pairs, "R4 bit held two clocks", pairs, 1);
      end
    end
  endtask

  task automatic checkLoop();
    chk(rxN >= NV, "R8 loopback count", rxN, NV);
    for (int k = 0; k < NV; k++)
      chk(rxLog[k] === VEC[k], "R8 loopback order", rxLog[k], VEC[k]);
  endtask

  task automatic driveFull();
    for (int k = 1; k < NV; k++) begin
      @(posedge byteClk or negedge byteClk);
      #40 txData = VEC[k];
    end
  endtask

  task automatic driveHalf();
    for (int k = 1; k < NV; k++) begin
      @(negedge byteClk);
      #40 txData = GARB;     // present around the rising edge only
      #60 txData = VEC[k];
    end
  endtask

  task automatic resetPhase(input logic rate, input logic loop);
    rstN = 1'b0;
    rateFull = rate;
    loopEn = loop;
    txData = VEC[0];
    recOn = 1'b0;
    repeat (5) @(posedge bitClk);
    #2;
    chk(serOut === 1'b0, "R10 serOut in reset", serOut, 0);
    chk(rxValid === 1'b0, "R10 rxValid in reset", rxValid, 0);
    @(posedge bitClk);
    #2;
    rxN = 0;
    recN = 0;
    recOn = 1'b1;
    rstN = 1'b1;
  endtask

  task automatic finish();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    #100us;
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    // full rate from reset, loopback on
    resetPhase(1'b1, 1'b1);
    driveFull();
    repeat (150) @(posedge bitClk);
    #2 recOn = 1'b0;
    decode(1, 1'b1);
    checkLoop();

    // half rate from reset, loopback off
    resetPhase(1'b0, 1'b0);
    driveHalf();
    repeat (150) @(posedge bitClk);
    #2 recOn = 1'b0;
    decode(2, 1'b1);
    chk(rxN == 0, "R9 no loopback strobes", rxN, 0);

    // switch half to full without reset
    @(negedge byteClk);
    #40;
    rateFull = 1'b1;
    loopEn = 1'b1;
    txData = VEC[0];
    recN = 0;
    recOn = 1'b1;
    #30 rxN = 0;
    driveFull();
    repeat (150) @(posedge bitClk);
    #2 recOn = 1'b0;
    decode(1, 1'b0);
    checkLoop();

    finish();
  end
endmodule